// File: doc/BRIEF.md
# Received Word Text Record Formatter

This block turns one decoded serial-bus word into a short line of readable text. It takes the 16-bit payload and four status flags: word kind, long-gap seen, parity good and inversion active. It then sends a fixed 21-byte ASCII record out one byte per handshake. The byte stream uses valid/ready, so the record can go straight into a UART transmitter or a byte FIFO.

A record looks like `CMDS;D1;P1;I0;Hx5555` followed by a carriage return. The word input is a single strobe qualified by `word_ready`. `word_ready` is high only while no record is in flight. The block captures all fields when it accepts a word. It then ignores its word inputs until the terminator has been handed over.

Back-pressure rules on the output are as follows:
- A byte moves only on a cycle where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- `out_valid` is never withdrawn before its byte has moved.

Top module: `rx_word_text_fmt`

## Requirements
- R1: After reset, `word_ready` is 1 and `out_valid` is 0.
- R2: A word is accepted on a clock edge where `word_valid` and `word_ready` are both 1. In the next cycle `out_valid` is 1 and `word_ready` is 0, and `word_ready` stays 0 until the record ends.
- R3: Each record is exactly 21 bytes. The byte at index 4, 7, 10 and 13 (counting from 0) is `;` (0x3B). Index 5 is `D`, index 8 is `P`, index 11 is `I`, index 14 is `H` and index 15 is `x`.
- R4: Bytes 0 to 3 are `CMDS` when `word_is_cmd` was 1, and `DATA` when it was 0.
- R5: Byte 6 is `1` (0x31) when `word_gap` was 1, otherwise `0` (0x30).
- R6: Byte 9 is `1` when `word_par_ok` was 1, otherwise `0`.
- R7: Byte 12 is `1` when `word_inv` was 1, otherwise `0`.
- R8: Bytes 16 to 19 are the four hex digits of `word_data`, most significant nibble first. Digits are `0`-`9` (0x30-0x39) and uppercase `A`-`F` (0x41-0x46).
- R9: Byte 20 is a carriage return (0x0D), with no line feed after it. In the cycle after it is taken, `word_ready` is 1 and `out_valid` is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 with `out_data` unchanged.
- R11: Changes on `word_data`, the flags or `word_valid` while a record is in flight do not alter that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Decoded word present |
| word_ready | output | 1 | Formatter idle, word can be taken |
| word_data | input | 16 | Decoded payload |
| word_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| word_gap | input | 1 | Gap before word exceeded the limit |
| word_par_ok | input | 1 | Parity checked good |
| word_inv | input | 1 | Inversion applied to the received data |
| out_valid | output | 1 | Text byte available |
| out_ready | input | 1 | Sink takes the byte this cycle |
| out_data | output | 8 | ASCII byte |

## Verification
The assertions assume that reset is held low for at least one clock edge before any traffic. They also assume that `out_ready` is a plain level the sink may change at any cycle, with no obligation to accept. They take `word_valid` to be meaningful only when `word_ready` is high. The stimulus drives all inputs at falling edges and releases reset before the first word. It stalls the sink in several duty patterns. In one scenario it deliberately raises `word_valid` with unrelated data mid-record, so that the record's contents and end are checked against that misuse.

// File: rtl/txtfmt_pkg.sv
package txtfmt_pkg;

  typedef struct packed {
    logic is_cmd;
    logic gap;
    logic par_ok;
    logic inv;
  } word_flags_t;

  localparam logic [7:0] CH_SEP  = 8'h3B;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_ONE  = 8'h31;
  localparam logic [31:0] TXT_CMD  = 32'h434D4453;
  localparam logic [31:0] TXT_DATA = 32'h44415441;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

  function automatic logic [7:0] flag_ascii(input logic f);
    return f ? CH_ONE : CH_ZERO;
  endfunction

endpackage

// File: rtl/txtfmt_capture.sv
module txtfmt_capture
  import txtfmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  word_flags_t       flags_in,
  input  logic [DATA_W-1:0] data_in,
  output word_flags_t       flags_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
    end else if (load) begin
      flags_q <= flags_in;
      data_q  <= data_in;
    end
  end

endmodule

// File: rtl/txtfmt_sequencer.sv
module txtfmt_sequencer #(
  parameter int REC_LEN = 21,
  localparam int IDX_W  = $clog2(REC_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (advance) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_STALL_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !advance |=> busy && $stable(idx)); // R10

endmodule

// File: rtl/txtfmt_char_gen.sv
module txtfmt_char_gen
  import txtfmt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REC_LEN = 21,
  localparam int NIB    = DATA_W / 4,
  localparam int HEX_AT = 16,
  localparam int IDX_W  = $clog2(REC_LEN)
) (
  input  logic [IDX_W-1:0]  idx,
  input  word_flags_t       flags,
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        ch
);

  logic [3:0] nib [NIB];

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    assign nib[g] = data[DATA_W-1-4*g -: 4];
  end

  logic [31:0] sync_txt;
  assign sync_txt = flags.is_cmd ? TXT_CMD : TXT_DATA;

  always_comb begin
    ch = CH_CR;
    for (int k = 0; k < 4; k++)
      if (idx == IDX_W'(k)) ch = sync_txt[31-8*k -: 8];
    case (idx)
      IDX_W'(4), IDX_W'(7), IDX_W'(10), IDX_W'(13): ch = CH_SEP;
      IDX_W'(5):  ch = 8'h44;
      IDX_W'(6):  ch = flag_ascii(flags.gap);
      IDX_W'(8):  ch = 8'h50;
      IDX_W'(9):  ch = flag_ascii(flags.par_ok);
      IDX_W'(11): ch = 8'h49;
      IDX_W'(12): ch = flag_ascii(flags.inv);
      IDX_W'(14): ch = 8'h48;
      IDX_W'(15): ch = 8'h78;
      default: ;
    endcase
    for (int k = 0; k < NIB; k++)
      if (idx == IDX_W'(HEX_AT + k)) ch = nib_to_ascii(nib[k]);
  end

endmodule

// File: rtl/rx_word_text_fmt.sv
module rx_word_text_fmt
  import txtfmt_pkg::*;
#(
  parameter int DATA_W   = 16,
  localparam int NIB     = DATA_W / 4,
  localparam int REC_LEN = 17 + NIB,
  localparam int IDX_W   = $clog2(REC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_is_cmd,
  input  logic              word_gap,
  input  logic              word_par_ok,
  input  logic              word_inv,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);

  logic              busy;
  logic              accept;
  logic [IDX_W-1:0]  idx;
  word_flags_t       flags_in, flags_q;
  logic [DATA_W-1:0] data_q;

  assign flags_in   = '{is_cmd: word_is_cmd, gap: word_gap, par_ok: word_par_ok, inv: word_inv};
  assign word_ready = !busy;
  assign out_valid  = busy;
  assign accept     = word_valid && !busy;

  txtfmt_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .flags_in(flags_in), .data_in(word_data),
    .flags_q(flags_q), .data_q(data_q)
  );

  txtfmt_sequencer #(.REC_LEN(REC_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .advance(out_ready), .busy(busy), .idx(idx)
  );

  txtfmt_char_gen #(.DATA_W(DATA_W), .REC_LEN(REC_LEN)) u_chars (
    .idx(idx), .flags(flags_q), .data(data_q), .ch(out_data)
  );

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready |=> out_valid && !word_ready); // R2

  AST_FIRST_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == 8'h43 || out_data == 8'h44)); // R4

  AST_CR_ENDS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_data == CH_CR |=> word_ready && !out_valid); // R9

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_BUSY_IGNORES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && word_valid && !(out_ready && out_data == CH_CR) |=> out_valid); // R11

endmodule

// File: tb/tb_rx_word_text_fmt.sv
module tb_rx_word_text_fmt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        word_is_cmd = 1'b0, word_gap = 1'b0, word_par_ok = 1'b0, word_inv = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_word_text_fmt dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .word_is_cmd(word_is_cmd), .word_gap(word_gap),
    .word_par_ok(word_par_ok), .word_inv(word_inv), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    string digits = "0123456789ABCDEF";
    return digits[n];
  endfunction

  function automatic logic [7:0] bit_ch(input logic b);
    return b ? 8'h31 : 8'h30;
  endfunction

  task automatic run_word(input logic [15:0] d, input logic c, input logic g,
                          input logic p, input logic v, input int mode, input bit meddle);
    logic [7:0] exp [21];
    logic [7:0] got [32];
    logic [31:0] sync;
    logic [7:0] prev;
    bit have_prev;
    int n;
    sync = c ? "CMDS" : "DATA";
    for (int k = 0; k < 4; k++) exp[k] = sync[31-8*k -: 8];
    exp[4] = ";"; exp[5] = "D"; exp[6] = bit_ch(g);
    exp[7] = ";"; exp[8] = "P"; exp[9] = bit_ch(p);
    exp[10] = ";"; exp[11] = "I"; exp[12] = bit_ch(v);
    exp[13] = ";"; exp[14] = "H"; exp[15] = "x";
    for (int k = 0; k < 4; k++) exp[16+k] = hexc(d[15-4*k -: 4]);
    exp[20] = 8'h0D;

    @(negedge clk);
    chk(word_ready == 1'b1, "R2 idle before accept", word_ready, 1);
    word_valid = 1'b1; word_data = d; word_is_cmd = c;
    word_gap = g; word_par_ok = p; word_inv = v;
    @(negedge clk);
    word_valid = 1'b0;
    chk(out_valid == 1'b1 && word_ready == 1'b0, "R2 busy after accept",
        {out_valid, word_ready}, 2'b10);
    n = 0; have_prev = 0;
    for (int i = 0; i < 200; i++) begin
      if (!out_valid) break;
      if (word_ready) chk(0, "R2 ready while busy", 1, 0);
      if (have_prev) begin
        chk(out_data == prev, "R10 byte held under stall", out_data, prev);
        have_prev = 0;
      end
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (i % 2) == 1;
        default: out_ready = (i % 3) == 2;
      endcase
      if (meddle) begin
        word_valid = (n < 17); word_data = ~d ^ 16'(i * 37);
        word_is_cmd = ~c; word_gap = ~g; word_par_ok = ~p; word_inv = ~v;
      end
      if (out_ready) begin
        if (n < 32) got[n] = out_data;
        n++;
      end else begin
        prev = out_data; have_prev = 1;
      end
      @(negedge clk);
    end
    word_valid = 1'b0; out_ready = 1'b0;
    chk(n == 21, "R3 record length", n, 21);
    chk(word_ready == 1'b1 && out_valid == 1'b0, "R9 idle after terminator",
        {word_ready, out_valid}, 2'b10);
    for (int k = 0; k < 21 && k < n; k++) begin
      string tag;
      if (k < 4)                          tag = "R4 sync text";
      else if (k == 6)                    tag = "R5 gap flag";
      else if (k == 9)                    tag = "R6 parity flag";
      else if (k == 12)                   tag = "R7 invert flag";
      else if (k >= 16 && k < 20)         tag = "R8 hex digit";
      else if (k == 20)                   tag = "R9 carriage return";
      else                                tag = "R3 separator/tag";
      if (meddle) tag = {tag, " R11"};
      chk(got[k] == exp[k], tag, got[k], exp[k]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(word_ready == 1'b1 && out_valid == 1'b0, "R1 reset state",
        {word_ready, out_valid}, 2'b10);
  endtask

  task automatic t_cmd_free_flow();
    run_word(16'h5555, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_data_alternate();
    run_word(16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
  endtask

  task automatic t_extremes_slow();
    run_word(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0);
    run_word(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 2, 0);
  endtask

  task automatic t_mixed_digits();
    run_word(16'h9C3E, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_meddle_inputs();
    run_word(16'h1B7D, 1'b0, 1'b1, 1'b1, 1'b0, 1, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_free_flow();
    t_data_alternate();
    t_extremes_slow();
    t_mixed_digits();
    t_meddle_inputs();
    t_cmd_free_flow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule